// File: doc/BRIEF.md
# Flip-Aware Scanline Interrupt Generator

This block keeps an 8-bit vertical line counter that runs freely and advances once per line strobe. From that counter it derives three outputs: the effective vertical position, a vertical-blank flag, and a level-type interrupt request for the CPU. When the display is flipped, the effective position runs backwards. It becomes the two's complement of the raw count, so the same rule converts raw lines to effective lines and effective lines back to raw lines.

The interrupt request follows the inverse of effective-V bit 5. The block refreshes it only on the lines that a /16V edge XORed with the flip state would clock. Those lines are every 32nd line, and their phase moves by 16 when the display is flipped. The result is that the request asserts on effective lines 0, 64, 128 and 192 when not flipped, and on 16, 80, 144 and 208 when flipped. Software does not acknowledge the request: it falls again 32 lines later without any action. The flip control is sampled only at a line boundary, so a change in the middle of a line has no effect until the next strobe.

Top module: `vsi_top`

## Requirements
- R1: `v_eff` equals the raw line count when the registered flip state is 0, and equals (256 - raw) mod 256 when it is 1.
- R2: The raw count starts at 0, rises by exactly one on each clock edge where `line_stb` is high, and wraps from 255 to 0. Under flip, raw = (256 - `v_eff`) mod 256.
- R3: `vblank` is 1 exactly when `v_eff` is below 24.
- R4: `irq` is updated only at a strobe whose new line has `v_eff` mod 32 equal to 0 (flip 0) or 16 (flip 1). At such a strobe `irq` takes the inverse of bit 5 of that new `v_eff`.
- R5: As a result, `irq` rises only on effective lines 0, 64, 128 and 192 (flip 0) or 16, 80, 144 and 208 (flip 1). It falls on lines where `v_eff` bit 5 is 1.
- R6: `flip_req` is sampled only on clock edges where `line_stb` is high. A change of `flip_req` between strobes leaves `v_eff`, `vblank` and `irq` unchanged.
- R7: `irq` is registered and holds its value on every clock edge that is not an update edge from R4.
- R8: While `rst_n` is low, `irq` = 0, the flip state is 0 and the raw count is 0, so `v_eff` = 0 and `vblank` = 1. Counting resumes from the third clock edge after `rst_n` rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_stb | input | 1 | One-cycle pulse at each line boundary |
| flip_req | input | 1 | Requested flip state, taken at the next strobe |
| irq | output | 1 | Level interrupt request to the CPU |
| vblank | output | 1 | High while effective V is below 24 |
| v_eff | output | 8 | Effective vertical line number |

## Verification
Three events can land on the same strobe: a flip change, an interrupt update, and a vertical-blank edge. Effective line 0 is both an interrupt-assert line and inside vblank. A new flip value can also remap the next line straight onto a sampling line of the other phase. The bench forces these collisions by toggling `flip_req` at random points, on strobe edges and between them, while strobes arrive with irregular gaps. A behavioural model written with integer arithmetic is compared with all three outputs on every clock.

// File: rtl/vsi_pkg.sv
package vsi_pkg;
  localparam int unsigned VSI_V_BITS     = 8;
  localparam int unsigned VSI_VBLANK_END = 24;
  localparam int unsigned VSI_IRQ_BIT    = 5;
  localparam int unsigned VSI_PHASE_BIT  = 4;
  localparam int unsigned VSI_SYNC_STAGES = 2;
endpackage

// File: rtl/vsi_line_ctr.sv
module vsi_line_ctr #(
  parameter int unsigned V_BITS = vsi_pkg::VSI_V_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_stb,
  input  logic              flip_req,
  output logic [V_BITS-1:0] raw_q,
  output logic              flip_q,
  output logic [V_BITS-1:0] raw_d,
  output logic              flip_d
);
  localparam logic [V_BITS-1:0] ONE = V_BITS'(1);

  // next-state: advance and resample flip only at a line boundary
  always_comb begin
    raw_d  = raw_q;
    flip_d = flip_q;
    if (line_stb) begin
      raw_d  = raw_q + ONE;
      flip_d = flip_req;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q  <= '0;
      flip_q <= 1'b0;
    end else if (line_stb) begin
      raw_q  <= raw_d;
      flip_q <= flip_d;
    end
  end

  // R2: one step per strobe, modulo wrap
  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    line_stb |=> raw_q == $past(raw_q) + ONE);
  // R6: flip state frozen inside a line
  a_r6_flip_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !line_stb |=> $stable(flip_q) && $stable(raw_q));
endmodule

// File: rtl/vsi_vmap.sv
module vsi_vmap #(
  parameter int unsigned V_BITS = vsi_pkg::VSI_V_BITS
) (
  input  logic [V_BITS-1:0] raw,
  input  logic              flip,
  output logic [V_BITS-1:0] v
);
  // flipped: count runs backwards, 2^V_BITS - raw
  always_comb begin
    if (flip) v = {V_BITS{1'b0}} - raw;
    else      v = raw;
  end
endmodule

// File: rtl/vsi_irq_samp.sv
module vsi_irq_samp #(
  parameter int unsigned V_BITS    = vsi_pkg::VSI_V_BITS,
  parameter int unsigned IRQ_BIT   = vsi_pkg::VSI_IRQ_BIT,
  parameter int unsigned PHASE_BIT = vsi_pkg::VSI_PHASE_BIT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_stb,
  input  logic [V_BITS-1:0] v_nxt,
  input  logic              flip_nxt,
  output logic              irq_q
);
  localparam logic [IRQ_BIT-1:0] PHASE_PAT = IRQ_BIT'(1) << PHASE_BIT;

  logic [IRQ_BIT-1:0] want_low;
  logic               hit;
  logic               irq_d;

  always_comb begin
    want_low = flip_nxt ? PHASE_PAT : '0;
    hit      = line_stb && (v_nxt[IRQ_BIT-1:0] == want_low);
    irq_d    = hit ? ~v_nxt[IRQ_BIT] : irq_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   irq_q <= 1'b0;
    else if (hit) irq_q <= irq_d;
  end

  // R7: no strobe, no change
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !line_stb |=> $stable(irq_q));
endmodule

// File: rtl/vsi_top.sv
module vsi_top #(
  parameter int unsigned V_BITS      = vsi_pkg::VSI_V_BITS,
  parameter int unsigned VBLANK_END  = vsi_pkg::VSI_VBLANK_END,
  parameter int unsigned IRQ_BIT     = vsi_pkg::VSI_IRQ_BIT,
  parameter int unsigned PHASE_BIT   = vsi_pkg::VSI_PHASE_BIT,
  parameter int unsigned SYNC_STAGES = vsi_pkg::VSI_SYNC_STAGES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_stb,
  input  logic              flip_req,
  output logic              irq,
  output logic              vblank,
  output logic [V_BITS-1:0] v_eff
);
  localparam logic [V_BITS-1:0]  VB_LIM    = V_BITS'(VBLANK_END);
  localparam logic [IRQ_BIT-1:0] PHASE_PAT = IRQ_BIT'(1) << PHASE_BIT;

  // asynchronous assert, synchronous release
  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_s_n = rst_pipe[SYNC_STAGES-1];

  logic [V_BITS-1:0] raw_q, raw_d, v_nxt;
  logic              flip_q, flip_d;

  vsi_line_ctr #(.V_BITS(V_BITS)) u_ctr (
    .clk(clk), .rst_n(rst_s_n), .line_stb(line_stb), .flip_req(flip_req),
    .raw_q(raw_q), .flip_q(flip_q), .raw_d(raw_d), .flip_d(flip_d)
  );

  vsi_vmap #(.V_BITS(V_BITS)) u_map_now (
    .raw(raw_q), .flip(flip_q), .v(v_eff)
  );

  vsi_vmap #(.V_BITS(V_BITS)) u_map_nxt (
    .raw(raw_d), .flip(flip_d), .v(v_nxt)
  );

  vsi_irq_samp #(.V_BITS(V_BITS), .IRQ_BIT(IRQ_BIT), .PHASE_BIT(PHASE_BIT)) u_irq (
    .clk(clk), .rst_n(rst_s_n), .line_stb(line_stb),
    .v_nxt(v_nxt), .flip_nxt(flip_d), .irq_q(irq)
  );

  assign vblank = (v_eff < VB_LIM);

  // R2: inverse mapping recovers the raw count
  a_r2_inverse: assert property (@(posedge clk) disable iff (!rst_s_n)
    (flip_q ? (V_BITS'(v_eff + raw_q) == '0) : (v_eff == raw_q)));
  // R5: rising request only on the phase lines of the current flip state
  a_r5_rise_line: assert property (@(posedge clk) disable iff (!rst_s_n)
    $rose(irq) |-> (!v_eff[IRQ_BIT] && v_eff[IRQ_BIT-1:0] == (flip_q ? PHASE_PAT : '0)));
  // R5: falling request only where bit 5 of V is set
  a_r5_fall_line: assert property (@(posedge clk) disable iff (!rst_s_n)
    $fell(irq) |-> v_eff[IRQ_BIT]);
  // R6: outputs stay put inside a line
  a_r6_line_stable: assert property (@(posedge clk) disable iff (!rst_s_n)
    !line_stb |=> $stable(v_eff) && $stable(vblank));
  // R8: reset state
  a_r8_reset: assert property (@(posedge clk)
    !rst_s_n |-> (!irq && v_eff == '0 && vblank));
endmodule

// File: tb/sim_vsi_top.sv
`timescale 1ns/1ps
module sim_vsi_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       line_stb;
  logic       flip_req;
  logic       irq;
  logic       vblank;
  logic [7:0] v_eff;

  int chk_n  = 0;
  int fail_n = 0;
  int cyc    = 0;
  bit done   = 0;

  // behavioural reference
  int m_raw  = 0;
  int m_flip = 0;
  int m_irq  = 0;
  int m_rel  = 0;

  always #2.5 clk = ~clk;

  vsi_top u0 (
    .clk(clk), .rst_n(rst_n), .line_stb(line_stb), .flip_req(flip_req),
    .irq(irq), .vblank(vblank), .v_eff(v_eff)
  );

  function automatic int eff(input int raw, input int fl);
    return fl ? ((256 - raw) % 256) : raw;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    chk_n++;
    if (!ok) begin
      fail_n++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", chk_n, fail_n);
    $finish;
  endtask

  // reference model: advances on the same edges as the design
  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_raw = 0; m_flip = 0; m_irq = 0; m_rel = 0;
    end else if (m_rel < 2) begin
      m_rel++;
    end else if (line_stb) begin
      int v;
      m_raw  = (m_raw + 1) % 256;
      m_flip = flip_req;
      v = eff(m_raw, m_flip);
      if ((v % 32) == (m_flip ? 16 : 0)) m_irq = ((v / 32) % 2 == 0) ? 1 : 0;
    end
    if (cyc > 150000 && !done) begin
      done = 1;
      fail_n++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      finish_run();
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      int v;
      v = eff(m_raw, m_flip);
      check(v_eff == v, "R1 R2 v_eff", v_eff, v);
      check(vblank == (v < 24), "R3 vblank", vblank, (v < 24));
      check(irq == m_irq, "R4 R5 R7 irq", irq, m_irq);
    end
  end

  task automatic one_line(input int gap);
    @(posedge clk); #1 line_stb = 1'b1;
    @(posedge clk); #1 line_stb = 1'b0;
    repeat (gap) @(posedge clk);
  endtask

  initial begin
    rst_n = 1'b0; line_stb = 1'b0; flip_req = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(irq == 1'b0, "R8 reset irq", irq, 0);
    check(v_eff == 8'd0, "R8 reset v_eff", v_eff, 0);
    check(vblank == 1'b1, "R8 reset vblank", vblank, 1);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // unflipped frames, back-to-back strobes
    for (int i = 0; i < 600; i++) begin
      @(posedge clk); #1 line_stb = 1'b1;
    end
    @(posedge clk); #1 line_stb = 1'b0;

    // flipped frames
    flip_req = 1'b1;
    for (int i = 0; i < 600; i++) one_line(0);

    // irregular strobes, flip moved on and between boundaries
    for (int i = 0; i < 2500; i++) begin
      int gap;
      gap = $urandom_range(0, 2);
      if ($urandom_range(0, 7) == 0) flip_req = ~flip_req;
      @(posedge clk); #1 line_stb = 1'b1;
      @(posedge clk); #1 line_stb = 1'b0;
      if (gap > 0 && $urandom_range(0, 3) == 0) begin
        logic [7:0] v0;
        logic       i0, b0;
        @(negedge clk);
        v0 = v_eff; i0 = irq; b0 = vblank;
        @(posedge clk); #1 flip_req = ~flip_req;
        @(negedge clk);
        check(v_eff == v0, "R6 mid-line v_eff", v_eff, v0);
        check(irq == i0, "R6 mid-line irq", irq, i0);
        check(vblank == b0, "R6 mid-line vblank", vblank, b0);
      end else begin
        repeat (gap) @(posedge clk);
      end
    end

    // reset again mid-frame
    @(posedge clk); #1 rst_n = 1'b0;
    @(negedge clk);
    check(irq == 1'b0 && v_eff == 8'd0, "R8 async reset", {irq, v_eff}, 0);
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    done = 1;
    finish_run();
  end
endmodule